// File: doc/BRIEF.md
# Microcontroller Program Counter Unit

This block holds the 13-bit fetch address of a small Harvard-architecture controller whose instruction words are 14 bits wide. It can address 8K instruction words. Each cycle it picks one source for the next address. It can increment, jump to the interrupt vector, take a computed target from a write to the low address register, take a jump or call target, or take a return address that an external stack supplies. It can also do nothing and hold. It also presents the low eight address bits and a separate 5-bit upper latch register, so that surrounding logic can use both as special function registers.

The upper address bits never come straight from a data write. Software first loads the upper latch. Later, a write of the low byte copies all five latch bits into the address. A jump or call takes its low eleven bits from the instruction literal and only the top two bits from the latch. So a computed jump takes two register writes. Pushes and pops of return addresses leave the latch alone. On a call the unit offers the return address (the current address plus one) on its push port. On interrupt entry it offers the current address instead.

The next-address selector is a small set of named sources (`SRC_HOLD`, `SRC_INC`, `SRC_RET`, `SRC_JUMP`, `SRC_LOW`, `SRC_VEC`). Every source can be chosen in any cycle; the choice is a fixed priority over the request inputs:
- interrupt → `SRC_VEC`
- else low write → `SRC_LOW`
- else call or jump → `SRC_JUMP`
- else return → `SRC_RET`
- else advance → `SRC_INC`
- otherwise → `SRC_HOLD`

Asynchronous reset forces the address and latch to zero regardless of source.

Top module: `pc_unit`

## Requirements
- R1: While and after reset, with no other request, `pc`, `lo_rdata` and `lat_rdata` are all zero.
- R2: With only `adv` high, `pc` becomes the old `pc` plus one on the next edge, wrapping from 1FFFh to 0000h.
- R3: With `irq_take` high, `pc` becomes 0004h on the next edge; in that cycle `push_en` is 1 and `push_data` equals the current `pc`.
- R4: A low write (`lo_we`) loads `pc` with {latch bits 4:0, `lo_wdata`}, using the latch value held before any latch write in the same cycle; `lo_rdata` always equals `pc` bits 7:0.
- R5: A jump loads `pc` with {latch bits 4:3, `lit`}, where `lit` gives `pc` bits 10:0.
- R6: A call loads `pc` exactly as a jump does; in that cycle `push_en` is 1 and `push_data` equals `pc` plus one (wrapping).
- R7: A return loads `pc` with `ret_addr` and does not change the latch.
- R8: Priority is interrupt, then low write, then call or jump, then return, then advance; a lower request in the same cycle has no effect on `pc`.
- R9: `lat_rdata` shows the value last written through `lat_we`/`lat_wdata`; no other request changes it.
- R10: With no request high, `pc` keeps its value and `push_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_take | input | 1 | Enter the interrupt vector |
| adv | input | 1 | Advance to the next sequential address |
| jump | input | 1 | Take a jump target |
| call | input | 1 | Take a call target and push the return address |
| ret | input | 1 | Load the popped return address |
| lit | input | 11 | Jump/call literal, becomes pc bits 10:0 |
| ret_addr | input | 13 | Return address from the external stack |
| lo_we | input | 1 | Write the low address register |
| lo_wdata | input | 8 | Data for the low address register |
| lat_we | input | 1 | Write the upper latch register |
| lat_wdata | input | 5 | Data for the upper latch register |
| pc | output | 13 | Fetch address |
| lo_rdata | output | 8 | Read value of the low address register |
| lat_rdata | output | 5 | Read value of the upper latch register |
| push_en | output | 1 | Push request to the external stack |
| push_data | output | 13 | Address to push |

## Verification
The hardest case to reach is the address wrap from 1FFFh to 0000h. Incrementing from reset would take 8191 cycles. The bench reaches it in two steps: it loads the latch with all ones, then writes FFh to the low register, which puts `pc` at 1FFFh in one edge. One advance then checks the wrap. The same low-write path is used with a latch write in the same cycle, which shows that the computed target takes the old latch value. Combined requests (interrupt with low write and jump, low write with jump, jump with return) check that only the winning source changes the address.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    typedef enum logic [2:0] {
        SRC_HOLD = 3'd0,
        SRC_INC  = 3'd1,
        SRC_RET  = 3'd2,
        SRC_JUMP = 3'd3,
        SRC_LOW  = 3'd4,
        SRC_VEC  = 3'd5
    } pc_src_e;
endpackage

// File: rtl/pcu_src_sel.sv
module pcu_src_sel
    import pcu_pkg::*;
(
    input  logic    irq_take,
    input  logic    lo_we,
    input  logic    jump,
    input  logic    call,
    input  logic    ret,
    input  logic    adv,
    output pc_src_e src
);
    always_comb begin
        if (irq_take)          src = SRC_VEC;
        else if (lo_we)        src = SRC_LOW;
        else if (call || jump) src = SRC_JUMP;
        else if (ret)          src = SRC_RET;
        else if (adv)          src = SRC_INC;
        else                   src = SRC_HOLD;
    end
endmodule

// File: rtl/pcu_next.sv
module pcu_next
    import pcu_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int LIT_W = 11,
    parameter int VEC   = 4
) (
    input  pc_src_e               src,
    input  logic [PC_W-1:0]       pc,
    input  logic [PC_W-LO_W-1:0]  lat,
    input  logic [LO_W-1:0]       lo_wdata,
    input  logic [LIT_W-1:0]      lit,
    input  logic [PC_W-1:0]       ret_addr,
    output logic [PC_W-1:0]       nxt,
    output logic [PC_W-1:0]       pc_inc
);
    localparam int HI_W   = PC_W - LO_W;
    localparam int PAGE_W = PC_W - LIT_W;
    localparam logic [PC_W-1:0] ONE    = PC_W'(1);
    localparam logic [PC_W-1:0] VEC_PC = PC_W'(VEC);

    assign pc_inc = pc + ONE;

    always_comb begin
        unique case (src)
            SRC_VEC:  nxt = VEC_PC;
            SRC_LOW:  nxt = {lat, lo_wdata};
            SRC_JUMP: nxt = {lat[HI_W-1 -: PAGE_W], lit};
            SRC_RET:  nxt = ret_addr;
            SRC_INC:  nxt = pc_inc;
            default:  nxt = pc;
        endcase
    end
endmodule

// File: rtl/pcu_latch.sv
module pcu_latch #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/pc_unit.sv
module pc_unit
    import pcu_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int LIT_W = 11,
    parameter int VEC   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  irq_take,
    input  logic                  adv,
    input  logic                  jump,
    input  logic                  call,
    input  logic                  ret,
    input  logic [LIT_W-1:0]      lit,
    input  logic [PC_W-1:0]       ret_addr,
    input  logic                  lo_we,
    input  logic [LO_W-1:0]       lo_wdata,
    input  logic                  lat_we,
    input  logic [PC_W-LO_W-1:0]  lat_wdata,
    output logic [PC_W-1:0]       pc,
    output logic [LO_W-1:0]       lo_rdata,
    output logic [PC_W-LO_W-1:0]  lat_rdata,
    output logic                  push_en,
    output logic [PC_W-1:0]       push_data
);
    localparam int HI_W = PC_W - LO_W;

    pc_src_e          src;
    logic [PC_W-1:0]  nxt;
    logic [PC_W-1:0]  pc_inc;
    logic [HI_W-1:0]  lat_q;

    pcu_src_sel u_sel (
        .irq_take (irq_take),
        .lo_we    (lo_we),
        .jump     (jump),
        .call     (call),
        .ret      (ret),
        .adv      (adv),
        .src      (src)
    );

    pcu_latch #(.W(HI_W)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lat_we),
        .wdata (lat_wdata),
        .q     (lat_q)
    );

    pcu_next #(.PC_W(PC_W), .LO_W(LO_W), .LIT_W(LIT_W), .VEC(VEC)) u_nxt (
        .src      (src),
        .pc       (pc),
        .lat      (lat_q),
        .lo_wdata (lo_wdata),
        .lit      (lit),
        .ret_addr (ret_addr),
        .nxt      (nxt),
        .pc_inc   (pc_inc)
    );

    // address register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc <= '0;
        else        pc <= nxt;
    end

    // outputs
    always_comb begin
        lo_rdata  = pc[LO_W-1:0];
        lat_rdata = lat_q;
        unique case (src)
            SRC_VEC: begin
                push_en   = 1'b1;
                push_data = pc;
            end
            SRC_JUMP: begin
                push_en   = call;
                push_data = pc_inc;
            end
            default: begin
                push_en   = 1'b0;
                push_data = pc_inc;
            end
        endcase
    end
endmodule

// File: rtl/pcu_chk.sv
module pcu_chk #(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int LIT_W = 11,
    parameter int VEC   = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  irq_take,
    input logic                  adv,
    input logic                  jump,
    input logic                  call,
    input logic                  ret,
    input logic [LIT_W-1:0]      lit,
    input logic [PC_W-1:0]       ret_addr,
    input logic                  lo_we,
    input logic [LO_W-1:0]       lo_wdata,
    input logic                  lat_we,
    input logic [PC_W-LO_W-1:0]  lat_wdata,
    input logic [PC_W-1:0]       pc,
    input logic [PC_W-LO_W-1:0]  lat_rdata,
    input logic                  push_en,
    input logic [PC_W-1:0]       push_data
);
    localparam int HI_W   = PC_W - LO_W;
    localparam int PAGE_W = PC_W - LIT_W;
    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    logic quiet;
    assign quiet = !irq_take && !lo_we && !jump && !call && !ret;

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc == '0 && lat_rdata == '0)); // R1
    AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && adv) |=> pc == PC_W'($past(pc) + ONE)); // R2
    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> pc == PC_W'(VEC)); // R3
    AST_IRQ_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (push_en && push_data == pc)); // R3
    AST_LOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_take && lo_we) |=> pc == {$past(lat_rdata), $past(lo_wdata)}); // R4
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_take && !lo_we && (jump || call)) |=>
            pc == {$past(lat_rdata[HI_W-1 -: PAGE_W]), $past(lit)}); // R5
    AST_CALL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_take && !lo_we && call) |-> (push_en && push_data == PC_W'(pc + ONE))); // R6
    AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_take && !lo_we && !jump && !call && ret) |=> pc == $past(ret_addr)); // R7
    AST_LOW_OVER_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_take && lo_we && jump) |=> pc[LO_W-1:0] == $past(lo_wdata)); // R8
    AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        lat_we |=> lat_rdata == $past(lat_wdata)); // R9
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_we |=> $stable(lat_rdata)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !adv) |=> $stable(pc)); // R10
    AST_IDLE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |-> !push_en); // R10
endmodule

bind pc_unit pcu_chk #(.PC_W(PC_W), .LO_W(LO_W), .LIT_W(LIT_W), .VEC(VEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_take  (irq_take),
    .adv       (adv),
    .jump      (jump),
    .call      (call),
    .ret       (ret),
    .lit       (lit),
    .ret_addr  (ret_addr),
    .lo_we     (lo_we),
    .lo_wdata  (lo_wdata),
    .lat_we    (lat_we),
    .lat_wdata (lat_wdata),
    .pc        (pc),
    .lat_rdata (lat_rdata),
    .push_en   (push_en),
    .push_data (push_data)
);

// File: tb/sim_pc_unit.sv
module sim_pc_unit;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_take = 1'b0, adv = 1'b0, jump = 1'b0, call = 1'b0, ret = 1'b0;
    logic [10:0] lit = '0;
    logic [12:0] ret_addr = '0;
    logic        lo_we = 1'b0, lat_we = 1'b0;
    logic [7:0]  lo_wdata = '0;
    logic [4:0]  lat_wdata = '0;
    logic [12:0] pc, push_data;
    logic [7:0]  lo_rdata;
    logic [4:0]  lat_rdata;
    logic        push_en;

    pc_unit u0 (
        .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .adv(adv), .jump(jump),
        .call(call), .ret(ret), .lit(lit), .ret_addr(ret_addr), .lo_we(lo_we),
        .lo_wdata(lo_wdata), .lat_we(lat_we), .lat_wdata(lat_wdata), .pc(pc),
        .lo_rdata(lo_rdata), .lat_rdata(lat_rdata), .push_en(push_en),
        .push_data(push_data)
    );

    always #(PERIOD/2) clk = ~clk;

    typedef struct {
        logic [12:0] pc;
        logic [4:0]  lat;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0, n_fail = 0;
    logic [12:0] m_pc = '0;
    logic [4:0]  m_lat = '0;
    bit          done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: applies one cycle of requests, checks push port, queues expected state
    task automatic step(input bit i_irq, input bit i_adv, input bit i_jmp, input bit i_cal,
                        input bit i_ret, input bit i_low, input logic [7:0] i_lo,
                        input bit i_lw, input logic [4:0] i_lat, input logic [10:0] i_lit,
                        input logic [12:0] i_ra, input string tag);
        exp_t        e;
        bit          x_push;
        logic [12:0] x_pdata;
        @(negedge clk);
        irq_take = i_irq; adv = i_adv; jump = i_jmp; call = i_cal; ret = i_ret;
        lo_we = i_low; lo_wdata = i_lo; lat_we = i_lw; lat_wdata = i_lat;
        lit = i_lit; ret_addr = i_ra;
        #1;
        x_push = 0; x_pdata = '0;
        if (i_irq) begin x_push = 1; x_pdata = m_pc; end
        else if (!i_low && i_cal) begin x_push = 1; x_pdata = m_pc + 13'd1; end
        chk(push_en == x_push, {tag, " push_en"}, 32'(push_en), 32'(x_push));
        if (x_push) chk(push_data == x_pdata, {tag, " push_data"}, 32'(push_data), 32'(x_pdata));
        if (i_irq)                m_pc = 13'd4;
        else if (i_low)           m_pc = {m_lat, i_lo};
        else if (i_jmp || i_cal)  m_pc = {m_lat[4:3], i_lit};
        else if (i_ret)           m_pc = i_ra;
        else if (i_adv)           m_pc = m_pc + 13'd1;
        if (i_lw) m_lat = i_lat;
        e.pc = m_pc; e.lat = m_lat; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares outputs after each edge against the queue
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(pc == e.pc, {e.tag, " pc"}, 32'(pc), 32'(e.pc));
                chk(lat_rdata == e.lat, {e.tag, " latch"}, 32'(lat_rdata), 32'(e.lat));
                chk(lo_rdata == e.pc[7:0], {e.tag, " R4 lo_rdata"}, 32'(lo_rdata), 32'(e.pc[7:0]));
            end
        end
    end

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(pc == 13'd0, "R1 reset pc", 32'(pc), 0);
        chk(lat_rdata == 5'd0, "R1 reset latch", 32'(lat_rdata), 0);
        chk(lo_rdata == 8'd0, "R1 reset low", 32'(lo_rdata), 0);
        @(negedge clk); rst_n = 1'b1;
        //   irq adv jmp cal ret low lo     lw lat    lit      ra
        step(0, 0, 0, 0, 0, 0, 8'h00, 0, 5'h00, 11'h000, 13'h0000, "R1 post-reset idle");
        step(0, 1, 0, 0, 0, 0, 8'h00, 0, 5'h00, 11'h000, 13'h0000, "R2 inc");
        step(0, 1, 0, 0, 0, 0, 8'h00, 0, 5'h00, 11'h000, 13'h0000, "R2 inc");
        step(0, 1, 0, 0, 0, 0, 8'h00, 0, 5'h00, 11'h000, 13'h0000, "R2 inc");
        step(0, 0, 0, 0, 0, 0, 8'h00, 0, 5'h00, 11'h000, 13'h0000, "R10 hold");
        step(0, 1, 0, 0, 0, 0, 8'h00, 1, 5'h1A, 11'h000, 13'h0000, "R9 latch write");
        step(0, 0, 1, 0, 0, 0, 8'h00, 0, 5'h00, 11'h123, 13'h0000, "R5 jump");
        step(0, 0, 0, 1, 0, 0, 8'h00, 0, 5'h00, 11'h055, 13'h0000, "R6 call");
        step(0, 0, 0, 0, 1, 0, 8'h00, 0, 5'h00, 11'h000, 13'h1924, "R7 return");
        step(0, 0, 0, 0, 0, 1, 8'h80, 0, 5'h00, 11'h000, 13'h0000, "R4 low write");
        step(1, 1, 1, 0, 0, 1, 8'h33, 0, 5'h00, 11'h7FF, 13'h0000, "R3 R8 irq wins");
        step(0, 1, 1, 0, 0, 1, 8'h44, 0, 5'h00, 11'h2AA, 13'h0000, "R8 low over jump");
        step(0, 1, 1, 0, 1, 0, 8'h00, 0, 5'h00, 11'h011, 13'h0ABC, "R8 jump over return");
        step(0, 0, 0, 0, 1, 0, 8'h00, 0, 5'h00, 11'h000, 13'h0ABC, "R7 return latch kept");
        step(0, 0, 0, 0, 0, 0, 8'h00, 1, 5'h1F, 11'h000, 13'h0000, "R9 latch all ones");
        step(0, 0, 0, 0, 0, 1, 8'hFF, 0, 5'h00, 11'h000, 13'h0000, "R4 low to top");
        step(0, 1, 0, 0, 0, 0, 8'h00, 0, 5'h00, 11'h000, 13'h0000, "R2 wrap");
        step(0, 0, 0, 0, 0, 1, 8'h12, 1, 5'h05, 11'h000, 13'h0000, "R4 old latch used");
        step(0, 0, 0, 1, 0, 0, 8'h00, 0, 5'h00, 11'h3FF, 13'h0000, "R6 call page 0");
        step(0, 0, 0, 0, 0, 0, 8'h00, 0, 5'h00, 11'h000, 13'h0000, "R10 idle no push");
        @(posedge clk); #2;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule